// File: doc/BRIEF.md
# Multi-Step Accelerator Step Sequencer

This block drives a chain of processing steps across up to eight accelerators or DMA channels, with no processor action between steps. Software fills four step slots, each holding an 8-bit participation mask. It also chooses the first slot, the number of slots in the loop and a limit on the total number of steps. Then it raises `enable`. For each step the sequencer sends a one-cycle start strobe to every unit in the step's mask. It latches their completion strobes as they arrive. It advances only when all of them have reported and every participating unit shows that its memory traffic has drained.

Slots are visited in a ring. The walk begins at the chosen slot and moves upward, modulo four, through the configured number of slots, then jumps back to the first slot. A per-slot interrupt pulse marks the end of each step. A final interrupt pulse marks the step that reaches the limit, and the sequencer then goes idle. Software may rewrite the slots that are not running while a sequence is active. This lets a four-slot loop act as a window onto a longer program.

Top module: `seqr_top`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) leaves `busy`, `unit_start`, `step_irq`, `done_irq` and `cur_step` all zero.
- R2: A sequence launches on a rising edge of `enable` seen while idle with a nonzero `step_limit`. In the following cycle `busy` is 1, `cur_step` equals `start_step`, and `unit_start` equals the mask of that slot (slot n's mask is `slot_masks[8n+7:8n]`, bit u selects unit u).
- R3: `unit_start` is high for exactly one cycle at the start of each step, only on units in that step's mask, and is never high while `busy` is 0.
- R4: Completion strobes on `unit_done` from the selected units may come in any order and on different cycles. Each one is remembered, and a step cannot finish before the last selected unit has reported.
- R5: A step finishes only in a cycle in which every unit in its mask also shows `unit_idle` = 1. Its interrupt then appears in the following cycle, and the next step's start strobe appears in that same cycle.
- R6: `seq_len_m1` = L gives a loop of L+1 slots. The slot order is start, start+1, ... (modulo 4), and after L+1 slots it returns to the start slot (for example 3,0,3,0 or 2,3,0,1,2,3).
- R7: When the step in slot n finishes, `step_irq` bit n pulses for one cycle, and at most one bit is ever set.
- R8: A counter counts finished steps. When the finished step brings it to `step_limit`, `done_irq` pulses in the same cycle as that step's `step_irq` bit and `busy` is 0 in that cycle. A new run needs another rising edge of `enable`.
- R9: A slot's mask is sampled only when its step begins. Rewriting it during the step changes neither the start strobe already sent nor the units waited on.
- R10: A step whose mask is zero sends no start strobe and finishes in the cycle after it begins.
- R11: A completion strobe from a unit outside the running step's mask has no effect. The step stays busy and raises no interrupt.
- R12: `enable` low while busy aborts the run. In the next cycle `busy`, `unit_start`, `step_irq` and `done_irq` are all 0, even when the last completion strobe arrives in that same cycle.
- R13: Launching with `step_limit` = 0 runs no step. `done_irq` pulses for one cycle in the cycle after the launch edge, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Rising edge launches a run, low aborts it |
| start_step | input | SLOT_W (2) | First slot of the loop |
| seq_len_m1 | input | SLOT_W (2) | Slots in the loop, minus one |
| step_limit | input | LIMIT_W (26) | Total steps to run |
| slot_masks | input | N_SLOTS*N_UNITS (32) | Four packed participation masks |
| unit_done | input | N_UNITS (8) | Completion strobes from the units |
| unit_idle | input | N_UNITS (8) | High when a unit has no memory access in flight |
| unit_start | output | N_UNITS (8) | Start strobes to the units |
| step_irq | output | N_SLOTS (4) | Per-slot step-finished pulse |
| done_irq | output | 1 | Run-finished pulse |
| busy | output | 1 | A run is active |
| cur_step | output | SLOT_W (2) | Slot of the current (or last) step |

## Verification
Two events can share a single cycle. The completion of the last step coincides with the end of the run, so one step interrupt and `done_irq` must appear together with `busy` already low. The bench drives runs of several lengths to their limits and checks both pulses in that cycle. The second collision is a final completion strobe arriving in the same cycle as `enable` falling. The bench holds a unit's strobe under manual control, raises it in the same cycle that it drops `enable`, and expects the abort to win: no interrupt of either kind and `busy` low in the following cycle.

// File: rtl/seqr_pkg.sv
// Shared defaults and types for the step sequencer.
// Assumes: slot count is a power of two so the slot index wraps naturally.
package seqr_pkg;
    localparam int unsigned DEF_UNITS   = 8;
    localparam int unsigned DEF_SLOTS   = 4;
    localparam int unsigned DEF_LIMIT_W = 26;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/seqr_sync_tracker.sv
// Tracks which participating units of the running step still owe a
// completion strobe, and which must still drain their memory traffic.
// Assumes: load and clear are never high together; load wins over a
// completion strobe seen in the same cycle.
module seqr_sync_tracker #(
    parameter int unsigned N_UNITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic [N_UNITS-1:0] load_mask,
    input  logic [N_UNITS-1:0] unit_done,
    input  logic [N_UNITS-1:0] unit_idle,
    output logic [N_UNITS-1:0] act_mask,
    output logic               step_done
);
    logic [N_UNITS-1:0] waiting;
    logic [N_UNITS-1:0] draining;

    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            logic pend_q;
            logic part_q;

            // Per-unit pending-strobe and participation flags.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    pend_q <= 1'b0;
                    part_q <= 1'b0;
                end else if (load) begin
                    pend_q <= load_mask[u];
                    part_q <= load_mask[u];
                end else if (unit_done[u]) begin
                    pend_q <= 1'b0;
                end
            end

            assign waiting[u]  = pend_q & ~unit_done[u];
            assign draining[u] = part_q & ~unit_idle[u];
            assign act_mask[u] = part_q;
        end
    endgenerate

    // Step may finish once no strobe is owed and no access is in flight.
    assign step_done = ~|waiting && ~|draining;
endmodule

// File: rtl/seqr_slot_walker.sv
// Holds the current slot index and its position inside the loop, and
// computes the slot that follows it.
// Assumes: N_SLOTS is a power of two, len_m1 < N_SLOTS.
module seqr_slot_walker #(
    parameter int unsigned N_SLOTS = 4,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              advance,
    input  logic [SLOT_W-1:0] start_idx,
    input  logic [SLOT_W-1:0] len_m1,
    output logic [SLOT_W-1:0] cur_idx,
    output logic [SLOT_W-1:0] nxt_idx
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_SLOTS - 1);

    logic [SLOT_W-1:0] idx_q, pos_q, first_q, len_q;
    logic              wrap;

    // Loop end reached: next slot is the first one again.
    always_comb begin
        wrap = (pos_q == len_q);
        if (wrap)
            nxt_idx = first_q;
        else if (idx_q == LAST)
            nxt_idx = '0;
        else
            nxt_idx = idx_q + SLOT_W'(1);
    end

    // Latch loop shape at launch, step through it on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            pos_q   <= '0;
            first_q <= '0;
            len_q   <= '0;
        end else if (launch) begin
            idx_q   <= start_idx;
            pos_q   <= '0;
            first_q <= start_idx;
            len_q   <= len_m1;
        end else if (advance) begin
            idx_q <= nxt_idx;
            pos_q <= wrap ? '0 : pos_q + SLOT_W'(1);
        end
    end

    assign cur_idx = idx_q;
endmodule

// File: rtl/seqr_step_counter.sv
// Counts finished steps of a run and flags the step that reaches the limit.
// Assumes: the limit is captured at launch and is nonzero for a real run.
module seqr_step_counter #(
    parameter int unsigned LIMIT_W = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               advance,
    input  logic [LIMIT_W-1:0] limit,
    output logic               at_last
);
    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [LIMIT_W:0]   cnt_inc;

    // Finished-step count, one bit wider so the top value compares cleanly.
    assign cnt_inc = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
    assign at_last = (cnt_inc == {1'b0, limit_q});

    // Clear and capture the limit at launch, count on every finished step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (launch) begin
            cnt_q   <= '0;
            limit_q <= limit;
        end else if (advance) begin
            cnt_q <= cnt_inc[LIMIT_W-1:0];
        end
    end
endmodule

// File: rtl/seqr_top.sv
// Step sequencer top: launches a looped run of steps over the slot masks,
// strobes the units, waits for strobes and drain, raises interrupts.
// Assumes: all inputs are synchronous to clk; abort wins over completion.
module seqr_top
    import seqr_pkg::*;
#(
    parameter int unsigned N_UNITS = DEF_UNITS,
    parameter int unsigned N_SLOTS = DEF_SLOTS,
    parameter int unsigned LIMIT_W = DEF_LIMIT_W,
    localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic [SLOT_W-1:0]          start_step,
    input  logic [SLOT_W-1:0]          seq_len_m1,
    input  logic [LIMIT_W-1:0]         step_limit,
    input  logic [N_SLOTS*N_UNITS-1:0] slot_masks,
    input  logic [N_UNITS-1:0]         unit_done,
    input  logic [N_UNITS-1:0]         unit_idle,
    output logic [N_UNITS-1:0]         unit_start,
    output logic [N_SLOTS-1:0]         step_irq,
    output logic                       done_irq,
    output logic                       busy,
    output logic [SLOT_W-1:0]          cur_step
);
    seq_state_t         state_q, state_d;
    logic               en_q;
    logic [N_UNITS-1:0] mask_arr [N_SLOTS];
    logic [N_UNITS-1:0] act_mask, load_mask;
    logic [SLOT_W-1:0]  cur_idx, nxt_idx, load_sel;
    logic [N_SLOTS-1:0] cur_onehot;
    logic               step_done, at_last;
    logic               launch_req, limit_zero, launch, abort;
    logic               complete, finish, advance, load, clear;
    logic [N_UNITS-1:0] start_q;
    logic [N_SLOTS-1:0] sirq_q;
    logic               done_q;

    generate
        for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
            assign mask_arr[g] = slot_masks[g*N_UNITS +: N_UNITS];
        end
    endgenerate

    // Run control: launch, abort, step completion and final step.
    always_comb begin
        launch_req = (state_q == SEQ_IDLE) && enable && !en_q;
        limit_zero = (step_limit == '0);
        launch     = launch_req && !limit_zero;
        abort      = (state_q == SEQ_RUN) && !enable;
        complete   = (state_q == SEQ_RUN) && enable && step_done;
        finish     = complete && at_last;
        advance    = complete && !at_last;
        load       = launch || advance;
        clear      = abort || finish;
        load_sel   = launch ? start_step : nxt_idx;
        load_mask  = mask_arr[load_sel];
    end

    // Next run state.
    always_comb begin
        state_d = state_q;
        if (launch)
            state_d = SEQ_RUN;
        else if (clear)
            state_d = SEQ_IDLE;
    end

    // One-hot form of the running slot for the step interrupt.
    always_comb begin
        cur_onehot          = '0;
        cur_onehot[cur_idx] = 1'b1;
    end

    // State, enable history and registered strobes / interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            en_q    <= 1'b0;
            start_q <= '0;
            sirq_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= enable;
            start_q <= load ? load_mask : '0;
            sirq_q  <= complete ? cur_onehot : '0;
            done_q  <= finish || (launch_req && limit_zero);
        end
    end

    seqr_sync_tracker #(.N_UNITS(N_UNITS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load      (load),
        .load_mask (load_mask),
        .unit_done (unit_done),
        .unit_idle (unit_idle),
        .act_mask  (act_mask),
        .step_done (step_done)
    );

    seqr_slot_walker #(.N_SLOTS(N_SLOTS)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .advance   (advance),
        .start_idx (start_step),
        .len_m1    (seq_len_m1),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx)
    );

    seqr_step_counter #(.LIMIT_W(LIMIT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .advance (complete),
        .limit   (step_limit),
        .at_last (at_last)
    );

    assign unit_start = start_q;
    assign step_irq   = sirq_q;
    assign done_irq   = done_q;
    assign busy       = (state_q == SEQ_RUN);
    assign cur_step   = cur_idx;
endmodule

// File: rtl/seqr_checker.sv
// Property checker for seqr_top, attached by bind below.
// Assumes: the bound instance uses the same parameter values.
module seqr_checker #(
    parameter int unsigned N_UNITS = 8,
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned SLOT_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               busy,
    input logic               done_irq,
    input logic [N_UNITS-1:0] unit_start,
    input logic [N_UNITS-1:0] unit_idle,
    input logic [N_UNITS-1:0] act_mask,
    input logic [N_SLOTS-1:0] step_irq,
    input logic [SLOT_W-1:0]  cur_step
);
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_start) |-> busy)
        else $error("start strobe outside a run");

    p_irq_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_irq))
        else $error("more than one step interrupt");

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && (unit_start == '0)))
        else $error("done interrupt while still running");

    p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enable) |=> (!busy && (step_irq == '0) && !done_irq))
        else $error("abort left activity behind");

    p_step_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cur_step != $past(cur_step))) |-> (step_irq != '0))
        else $error("slot changed without a finished step");

    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_irq != '0) |-> $past((act_mask & ~unit_idle) == '0))
        else $error("step finished with traffic in flight");
endmodule

bind seqr_top seqr_checker #(
    .N_UNITS (N_UNITS),
    .N_SLOTS (N_SLOTS),
    .SLOT_W  (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .busy       (busy),
    .done_irq   (done_irq),
    .unit_start (unit_start),
    .unit_idle  (unit_idle),
    .act_mask   (act_mask),
    .step_irq   (step_irq),
    .cur_step   (cur_step)
);

// File: tb/seqr_top_test.sv
`timescale 1ns/1ps
// Bench for seqr_top: behavioural reference model compared every clock,
// a delay-driven unit responder, and directed scenarios per requirement.
module seqr_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  start_step = '0;
    logic [1:0]  seq_len_m1 = '0;
    logic [25:0] step_limit = '0;
    logic [31:0] slot_masks = '0;
    logic [7:0]  unit_done, unit_idle;
    logic [7:0]  unit_start;
    logic [3:0]  step_irq;
    logic        done_irq, busy;
    logic [1:0]  cur_step;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    seqr_top uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_step(start_step),
        .seq_len_m1(seq_len_m1), .step_limit(step_limit), .slot_masks(slot_masks),
        .unit_done(unit_done), .unit_idle(unit_idle), .unit_start(unit_start),
        .step_irq(step_irq), .done_irq(done_irq), .busy(busy), .cur_step(cur_step)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Unit responder: strobe done ddly cycles after start, drain after that.
    int ddly[8], drain[8], dcnt[8], icnt[8];
    logic [7:0] resp_en = 8'hFF;
    logic [7:0] r_done = '0, r_idle = 8'hFF, st_s = '0;
    logic [7:0] man_done = '0, man_idle = 8'hFF;
    assign unit_done = r_done | man_done;
    assign unit_idle = r_idle & man_idle;

    always @(negedge clk) st_s = unit_start;

    always @(posedge clk) begin
        #1;
        for (int u = 0; u < 8; u++) begin
            r_done[u] = 1'b0;
            if (st_s[u] === 1'b1 && resp_en[u]) begin
                dcnt[u] = ddly[u];
                icnt[u] = ddly[u] + drain[u];
                r_idle[u] = 1'b0;
            end else begin
                if (dcnt[u] > 0) begin
                    dcnt[u]--;
                    if (dcnt[u] == 0) r_done[u] = 1'b1;
                end
                if (icnt[u] > 0) begin
                    icnt[u]--;
                    if (icnt[u] == 0) r_idle[u] = 1'b1;
                end
            end
        end
    end

    // Reference model: expected outputs after each edge.
    int m_busy = 0, m_idx = 0, m_pos = 0, m_cnt = 0, m_first = 0, m_len = 0, m_lim = 0;
    logic [7:0] m_rem = '0, m_act = '0, e_start = '0;
    logic [3:0] e_sirq = '0;
    logic e_done = 0, m_en_q = 0;
    bit live = 0;

    function automatic logic [7:0] mask_of(input int s);
        return slot_masks[s*8 +: 8];
    endfunction

    always @(posedge clk) begin
        logic [7:0] nrem;
        live = 1;
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_pos = 0; m_cnt = 0; m_rem = '0; m_act = '0;
            e_start = '0; e_sirq = '0; e_done = 0; m_en_q = 0;
        end else begin
            e_start = '0; e_sirq = '0; e_done = 0;
            if (m_busy != 0) begin
                if (!enable) begin
                    m_busy = 0; m_rem = '0; m_act = '0;
                end else begin
                    nrem = m_rem & ~unit_done;
                    if (nrem == 0 && (m_act & ~unit_idle) == 0) begin
                        e_sirq[m_idx] = 1'b1;
                        m_cnt++;
                        if (m_cnt == m_lim) begin
                            e_done = 1; m_busy = 0; m_rem = '0; m_act = '0;
                        end else begin
                            if (m_pos == m_len) begin m_idx = m_first; m_pos = 0; end
                            else begin m_idx = (m_idx + 1) % 4; m_pos++; end
                            m_act = mask_of(m_idx); m_rem = m_act; e_start = m_act;
                        end
                    end else m_rem = nrem;
                end
            end else if (enable && !m_en_q) begin
                m_lim = int'(step_limit);
                if (m_lim == 0) e_done = 1;
                else begin
                    m_busy = 1; m_first = int'(start_step); m_idx = m_first; m_pos = 0;
                    m_len = int'(seq_len_m1); m_cnt = 0;
                    m_act = mask_of(m_idx); m_rem = m_act; e_start = m_act;
                end
            end
            m_en_q = enable;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) if (live && !finished) begin
        chk("R3 model start strobe", unit_start, e_start);
        chk("R7 model step interrupt", step_irq, e_sirq);
        chk("R8 model done interrupt", done_irq, e_done);
        chk("R12 model busy", busy, m_busy);
        chk("R6 model slot index", cur_step, m_idx);
    end

    // Log of finished slots in order.
    int irq_log[$];
    always @(negedge clk) if (rst_n && step_irq != '0)
        for (int s = 0; s < 4; s++) if (step_irq[s] === 1'b1) irq_log.push_back(s);

    task automatic go_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input int s, input int l, input int lim, input int exp[8]);
        int g;
        irq_log.delete();
        go_cycles(1);
        start_step = 2'(s); seq_len_m1 = 2'(l); step_limit = 26'(lim); enable = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 busy after launch", busy, 1);
        chk("R2 first slot", cur_step, s);
        chk("R2 first start strobe", unit_start, mask_of(s));
        @(negedge clk);
        chk("R3 strobe lasts one cycle", unit_start, 0);
        g = 0;
        while (!done_irq && g < 3000) begin @(negedge clk); g++; end
        chk("R8 done interrupt seen", done_irq, 1);
        chk("R8 idle at done", busy, 0);
        chk("R7 last step interrupt with done", (step_irq != 0), 1);
        @(negedge clk);
        chk("R6 step count", irq_log.size(), lim);
        for (int i = 0; i < lim && i < 8; i++)
            if (i < irq_log.size()) chk("R6 slot order", irq_log[i], exp[i]);
        go_cycles(4);
        chk("R8 no relaunch while enable held", busy, 0);
        enable = 0;
        go_cycles(20);
    endtask

    task automatic measure(input logic [7:0] m, input int exp_lat, input string tag);
        int t0, t1, g;
        go_cycles(1);
        slot_masks[7:0] = m; start_step = 0; seq_len_m1 = 0; step_limit = 1; enable = 1;
        g = 0;
        do begin @(negedge clk); g++; end while (unit_start == 0 && g < 100);
        t0 = cyc;
        g = 0;
        do begin @(negedge clk); g++; end while (step_irq == 0 && g < 500);
        t1 = cyc;
        chk(tag, t1 - t0, exp_lat);
        go_cycles(1);
        enable = 0;
        go_cycles(30);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!finished) begin
            n_err++;
            $display("FAIL R8 watchdog: actual hang expected finish");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int t0, t1, g;
        for (int u = 0; u < 8; u++) begin
            ddly[u] = u + 1; drain[u] = u % 3; dcnt[u] = 0; icnt[u] = 0;
        end
        slot_masks = {8'hC0, 8'h30, 8'h0C, 8'h03};
        go_cycles(5);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 start after reset", unit_start, 0);
        chk("R1 step irq after reset", step_irq, 0);
        chk("R1 done after reset", done_irq, 0);
        chk("R1 slot after reset", cur_step, 0);

        // Looped runs of several shapes (R6, R7, R8).
        run_seq(1, 1, 5, '{1, 2, 1, 2, 1, 0, 0, 0});
        run_seq(3, 1, 4, '{3, 0, 3, 0, 0, 0, 0, 0});
        run_seq(2, 3, 6, '{2, 3, 0, 1, 2, 3, 0, 0});

        // R4: strobes out of order, step ends with the later one.
        ddly[0] = 7; drain[0] = 0; ddly[2] = 3; drain[2] = 0;
        measure(8'h05, 9, "R4 waits for all strobes");
        // R5: drain holds the step past its strobe.
        ddly[0] = 2; drain[0] = 9;
        measure(8'h01, 13, "R5 waits for drain");

        // R10: zero mask step.
        go_cycles(1);
        slot_masks[7:0] = 8'h00; start_step = 0; seq_len_m1 = 0; step_limit = 1; enable = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 busy on empty step", busy, 1);
        chk("R10 no strobe on empty step", unit_start, 0);
        @(negedge clk);
        chk("R10 empty step finished", step_irq, 4'b0001);
        chk("R10 run done", done_irq, 1);
        go_cycles(1); enable = 0; go_cycles(10);

        // R9: rewrite a running slot's mask.
        ddly[0] = 6; drain[0] = 0; resp_en = 8'h7F;
        go_cycles(1);
        slot_masks[7:0] = 8'h01; enable = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 start strobe", unit_start, 8'h01);
        t0 = cyc;
        slot_masks[7:0] = 8'h80;
        g = 0;
        do begin @(negedge clk); g++; end while (step_irq == 0 && g < 200);
        t1 = cyc;
        chk("R9 mask sampled at step begin", t1 - t0, 8);
        go_cycles(1); enable = 0; slot_masks[7:0] = 8'h01; go_cycles(20);

        // R11: foreign strobe ignored, own strobe finishes the step.
        resp_en = 8'hFE;
        irq_log.delete();
        go_cycles(1);
        enable = 1;
        go_cycles(3);
        man_done = 8'h02;
        go_cycles(1);
        man_done = 8'h00;
        go_cycles(3);
        @(negedge clk);
        chk("R11 still busy", busy, 1);
        chk("R11 no interrupt", irq_log.size(), 0);
        go_cycles(1);
        man_done = 8'h01;
        go_cycles(1);
        man_done = 8'h00;
        @(negedge clk);
        chk("R4 own strobe finishes step", step_irq, 4'b0001);
        chk("R8 single-step run done", done_irq, 1);
        go_cycles(1);

        // R12: plain abort, then abort colliding with the last strobe.
        enable = 0;
        go_cycles(2);
        enable = 1;
        go_cycles(3);
        enable = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 abort idle", busy, 0);
        chk("R12 abort no strobe", unit_start, 0);
        chk("R12 abort no step irq", step_irq, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12 quiet after abort", {step_irq, done_irq}, 0);
        end
        go_cycles(1);
        enable = 1;
        go_cycles(3);
        man_done = 8'h01;
        enable = 0;
        go_cycles(1);
        man_done = 8'h00;
        @(negedge clk);
        chk("R12 abort beats completion busy", busy, 0);
        chk("R12 abort beats completion irq", step_irq, 0);
        chk("R12 abort beats completion done", done_irq, 0);
        go_cycles(5);

        // R13: zero limit.
        resp_en = 8'hFF;
        go_cycles(1);
        step_limit = 0; enable = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R13 done at once", done_irq, 1);
        chk("R13 stays idle", busy, 0);
        chk("R13 no strobe", unit_start, 0);
        chk("R13 no step irq", step_irq, 0);
        @(negedge clk);
        chk("R13 done is a pulse", done_irq, 0);
        go_cycles(1); enable = 0; go_cycles(5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule